// File: doc/BRIEF.md
# Time-Counter Frequency Servo

This block keeps a local time counter running at the rate of a remote master clock. A 32-bit phase accumulator adds a programmable increment (the addend) on every reference clock. Each carry out of the accumulator advances a sub-second counter, which the block drives out as its local time. After reset the addend holds a nominal value set by a division-ratio parameter, so the counter starts at roughly the right rate before any correction.

Each time the surrounding logic handles a Sync exchange, it pulses `sync_valid` together with three timestamps: the master's send time, the measured path delay, and the local time at which the message arrived. The servo keeps the previous pair of master-side and local-side times. From the current and previous pairs it forms a master interval and a local interval. It then rescales the addend by (2·master − local) / local, which is the master interval plus the master-minus-local difference, divided by the local interval. The path delay is assumed to be the same for two consecutive Syncs. The multiply runs as a shift-and-add sequence and the divide as a restoring sequence. `busy` stays high while these run. A division by zero, a negative scale, or a quotient wider than the addend leaves the addend unchanged and raises a one-cycle error pulse.

The control state machine has five states:
- IDLE waits for a strobe. A strobe moves it to PREP, but only if a previous pair is stored.
- PREP goes back to IDLE with an error when the local interval is zero or the scale is negative. Otherwise it starts the multiply and goes to MUL.
- MUL moves to DIV when the product is ready.
- DIV moves to WRITE when the quotient is ready.
- WRITE loads the addend, or flags an overflow, and returns to IDLE.

Top module: `ptp_addend_servo`

## Requirements
- R1: After reset the addend equals floor(2^32 / DIV_RATIO), which is 85899345 for the default ratio of 50. After reset `local_time` is 0 and `busy` and `calc_error` are low.
- R2: On every clock the phase accumulator adds the addend modulo 2^32. Each carry out of bit 31 increments `local_time` by exactly one.
- R3: The first Sync after reset only stores its timestamps. `busy` stays low, the addend is unchanged and no error is raised.
- R4: The master clock time is the send time plus the path delay, modulo 2^32. The master interval is the current master clock time minus the previous one, and the local interval is the current receive time minus the previous one, both modulo 2^32.
- R5: For every later Sync the new addend is floor(old_addend × (2·M − S) / S), where M is the master interval and S is the local interval.
- R6: `busy` goes high in the cycle after an accepted Sync strobe that has a stored predecessor. It stays high until the cycle in which the new addend appears. The addend changes only in a cycle where `busy` has just fallen.
- R7: If S is zero, the addend is kept and `calc_error` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R8: If 2·M − S is negative, or the quotient does not fit in 32 bits, the addend is kept and the same one-cycle error pulse is produced.
- R9: A `sync_valid` strobe while `busy` is high is ignored. Its timestamps are neither stored nor used.
- R10: Every accepted Sync stores its master clock time and receive time as the previous pair, including Syncs that end in an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_valid | input | 1 | One-cycle strobe: the three timestamps are valid |
| sync_tx_time | input | TS_W | Master send time of the Sync |
| sync_path_delay | input | TS_W | Master-to-local path delay |
| sync_rx_time | input | TS_W | Local time at which the Sync arrived |
| addend | output | ADD_W | Current accumulator increment |
| busy | output | 1 | A new addend is being computed |
| calc_error | output | 1 | One-cycle pulse: the update was rejected |
| local_time | output | SUBSEC_W | Sub-second counter driven by accumulator carries |

## Verification
Wrong stored timestamps or a wrong interval do not show up when they are captured. They appear only when `busy` falls at the end of the next computation, as a wrong addend value. Within a few dozen clocks after that they also appear as a drift in the carry rate seen on `local_time`. Because the bench compares `local_time` on every clock against its own accumulator fed with the addend, a single bad carry is caught in the cycle it occurs. An error path taken when it should not be, or skipped when it should be taken, is seen in the first idle cycle as a missing or extra `calc_error` pulse. A Sync that should have been ignored but was stored shifts the intervals of the following Sync, so its addend comes out wrong.

// File: rtl/ptp_servo_pkg.sv
package ptp_servo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_MUL,
        ST_DIV,
        ST_WRITE
    } servo_state_t;

endpackage

// File: rtl/ptp_seq_mul.sv
module ptp_seq_mul #(
    parameter int A_W = 32,
    parameter int B_W = 33
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [A_W-1:0]     a,
    input  logic [B_W-1:0]     b,
    output logic               done,
    output logic [A_W+B_W-1:0] product
);
    localparam int P_W   = A_W + B_W;
    localparam int CNT_W = $clog2(B_W + 1);

    logic             running;
    logic [CNT_W-1:0] cnt;
    logic [P_W-1:0]   mcand;
    logic [B_W-1:0]   mplier;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            mcand   <= '0;
            mplier  <= '0;
            product <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                running <= 1'b1;
                cnt     <= CNT_W'(B_W);
                mcand   <= {{B_W{1'b0}}, a};
                mplier  <= b;
                product <= '0;
            end else if (running) begin
                if (mplier[0]) begin
                    product <= product + mcand;
                end
                mcand  <= mcand << 1;
                mplier <= mplier >> 1;
                cnt    <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    // R5
    mul_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt != '0));

    // R5
    mul_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running);

endmodule

// File: rtl/ptp_seq_div.sv
module ptp_seq_div #(
    parameter int N_W = 65,
    parameter int D_W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic           done,
    output logic [N_W-1:0] quotient
);
    localparam int CNT_W = $clog2(N_W + 1);

    logic             running;
    logic [CNT_W-1:0] cnt;
    logic [D_W-1:0]   rem;
    logic [D_W-1:0]   den;
    logic [D_W:0]     trial;
    logic [D_W:0]     diff;
    logic             fits;

    always_comb begin
        trial = {rem, quotient[N_W-1]};
        fits  = (trial >= {1'b0, den});
        diff  = trial - {1'b0, den};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            cnt      <= '0;
            rem      <= '0;
            den      <= '0;
            quotient <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                running  <= 1'b1;
                cnt      <= CNT_W'(N_W);
                rem      <= '0;
                den      <= divisor;
                quotient <= dividend;
            end else if (running) begin
                rem      <= fits ? diff[D_W-1:0] : trial[D_W-1:0];
                quotient <= {quotient[N_W-2:0], fits};
                cnt      <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    // R7: the control never starts a division by zero, so the partial remainder stays below the divisor
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (rem < den));

    // R5
    div_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running);

endmodule

// File: rtl/ptp_phase_accum.sv
module ptp_phase_accum #(
    parameter int ADD_W    = 32,
    parameter int SUBSEC_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADD_W-1:0]    addend,
    output logic [SUBSEC_W-1:0] local_time
);
    logic [ADD_W-1:0] phase;
    logic [ADD_W:0]   sum;

    always_comb sum = {1'b0, phase} + {1'b0, addend};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= '0;
            local_time <= '0;
        end else begin
            phase <= sum[ADD_W-1:0];
            if (sum[ADD_W]) begin
                local_time <= local_time + 1'b1;
            end
        end
    end

    // R2
    time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SUBSEC_W'(local_time - $past(local_time)) <= SUBSEC_W'(1)));

endmodule

// File: rtl/ptp_addend_servo.sv
module ptp_addend_servo
    import ptp_servo_pkg::*;
#(
    parameter int TS_W      = 32,
    parameter int ADD_W     = 32,
    parameter int SUBSEC_W  = 32,
    parameter int DIV_RATIO = 50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_valid,
    input  logic [TS_W-1:0]     sync_tx_time,
    input  logic [TS_W-1:0]     sync_path_delay,
    input  logic [TS_W-1:0]     sync_rx_time,
    output logic [ADD_W-1:0]    addend,
    output logic                busy,
    output logic                calc_error,
    output logic [SUBSEC_W-1:0] local_time
);
    localparam int NUM_W  = TS_W + 2;
    localparam int MAG_W  = TS_W + 1;
    localparam int PROD_W = ADD_W + MAG_W;
    localparam logic [ADD_W:0]   FULL_SCALE  = {1'b1, {ADD_W{1'b0}}};
    localparam logic [ADD_W:0]   INIT_WIDE   = FULL_SCALE / (ADD_W+1)'(DIV_RATIO);
    localparam logic [ADD_W-1:0] INIT_ADDEND = INIT_WIDE[ADD_W-1:0];

    servo_state_t state, state_nx;

    logic [TS_W-1:0]   prev_mct;
    logic [TS_W-1:0]   prev_rx;
    logic              have_prev;
    logic [TS_W-1:0]   m_cnt;
    logic [TS_W-1:0]   s_cnt;
    logic [TS_W-1:0]   cur_mct;
    logic [NUM_W-1:0]  scale_num;
    logic              reject;
    logic              mul_start;
    logic              mul_done;
    logic [PROD_W-1:0] product;
    logic              div_start;
    logic              div_done;
    logic [PROD_W-1:0] quotient;
    logic              too_wide;

    // Datapath helpers
    always_comb begin
        cur_mct   = sync_tx_time + sync_path_delay;
        scale_num = {1'b0, m_cnt, 1'b0} - {2'b00, s_cnt};
        reject    = (s_cnt == '0) || scale_num[NUM_W-1];
        too_wide  = |quotient[PROD_W-1:ADD_W];
        mul_start = (state == ST_PREP) && !reject;
        div_start = (state == ST_MUL) && mul_done;
        busy      = (state != ST_IDLE);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (sync_valid && have_prev) state_nx = ST_PREP;
            ST_PREP:  state_nx = reject ? ST_IDLE : ST_MUL;
            ST_MUL:   if (mul_done) state_nx = ST_DIV;
            ST_DIV:   if (div_done) state_nx = ST_WRITE;
            ST_WRITE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs and stored timestamps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_mct   <= '0;
            prev_rx    <= '0;
            have_prev  <= 1'b0;
            m_cnt      <= '0;
            s_cnt      <= '0;
            addend     <= INIT_ADDEND;
            calc_error <= 1'b0;
        end else begin
            calc_error <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (sync_valid) begin
                        m_cnt     <= cur_mct - prev_mct;
                        s_cnt     <= sync_rx_time - prev_rx;
                        prev_mct  <= cur_mct;
                        prev_rx   <= sync_rx_time;
                        have_prev <= 1'b1;
                    end
                end
                ST_PREP: begin
                    if (reject) calc_error <= 1'b1;
                end
                ST_WRITE: begin
                    if (too_wide) calc_error <= 1'b1;
                    else          addend     <= quotient[ADD_W-1:0];
                end
                default: ;
            endcase
        end
    end

    ptp_seq_mul #(.A_W(ADD_W), .B_W(MAG_W)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (mul_start),
        .a       (addend),
        .b       (scale_num[MAG_W-1:0]),
        .done    (mul_done),
        .product (product)
    );

    ptp_seq_div #(.N_W(PROD_W), .D_W(TS_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (product),
        .divisor  (s_cnt),
        .done     (div_done),
        .quotient (quotient)
    );

    ptp_phase_accum #(.ADD_W(ADD_W), .SUBSEC_W(SUBSEC_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .addend     (addend),
        .local_time (local_time)
    );

    // R6
    addend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addend) |-> $fell(busy));

    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        calc_error |=> !calc_error);

    // R8
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        calc_error |-> !busy);

    // R9
    prev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(prev_rx) && $stable(prev_mct)));

endmodule

// File: tb/tb_ptp_addend_servo.sv
`timescale 1ns/1ps
module tb_ptp_addend_servo;
    localparam logic [31:0] INIT_ADD = 32'd85899345;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_valid = 1'b0;
    logic [31:0] sync_tx_time = '0;
    logic [31:0] sync_path_delay = '0;
    logic [31:0] sync_rx_time = '0;
    logic [31:0] addend;
    logic        busy;
    logic        calc_error;
    logic [31:0] local_time;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural reference state
    logic [31:0] m_acc = '0;
    logic [31:0] m_time = '0;
    logic [31:0] seen_add = '0;
    logic [31:0] exp_now = INIT_ADD;
    logic [31:0] exp_old = INIT_ADD;
    logic [31:0] m_prev_mct = '0;
    logic [31:0] m_prev_rx = '0;
    bit          m_have = 1'b0;

    ptp_addend_servo dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .sync_valid      (sync_valid),
        .sync_tx_time    (sync_tx_time),
        .sync_path_delay (sync_path_delay),
        .sync_rx_time    (sync_rx_time),
        .addend          (addend),
        .busy            (busy),
        .calc_error      (calc_error),
        .local_time      (local_time)
    );

    always #2 clk = ~clk;

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-clock comparison of local time and addend
    always begin
        @(posedge clk);
        #1;
        cycles++;
        if (!rst_n) begin
            m_acc  = '0;
            m_time = '0;
        end else begin
            logic [32:0] s;
            s = {1'b0, m_acc} + {1'b0, seen_add};
            m_acc = s[31:0];
            if (s[32]) m_time = m_time + 1;
            check32("R2 local_time", local_time, m_time);
            check32("R6 addend", addend, busy ? exp_old : exp_now);
        end
        seen_add = addend;
    end

    task automatic do_sync(input logic [31:0] tx, input logic [31:0] dly, input logic [31:0] rx);
        logic [31:0]  mct, mi, si;
        longint       num;
        logic [127:0] q;
        bit           exp_err, computes;
        @(negedge clk);
        while (busy) @(negedge clk);
        mct = tx + dly;
        exp_err = 1'b0;
        computes = m_have;
        exp_old = exp_now;
        if (m_have) begin
            mi  = mct - m_prev_mct;
            si  = rx - m_prev_rx;
            num = 2 * longint'(mi) - longint'(si);
            if (si == 0 || num < 0) exp_err = 1'b1;
            else begin
                q = (128'(exp_now) * 128'(num)) / 128'(si);
                if (q[127:32] != 0) exp_err = 1'b1;
                else exp_now = q[31:0];
            end
        end
        m_prev_mct = mct;
        m_prev_rx  = rx;
        m_have     = 1'b1;
        sync_tx_time = tx; sync_path_delay = dly; sync_rx_time = rx;
        sync_valid = 1'b1;
        @(negedge clk);
        sync_valid = 1'b0;
        checks++;
        if (busy !== computes) begin
            fails++;
            $display("FAIL R6/R3 busy after strobe actual=%0b expected=%0b", busy, computes);
        end
        while (busy) @(negedge clk);
        checks++;
        if (calc_error !== exp_err) begin
            fails++;
            $display("FAIL R7/R8 calc_error actual=%0b expected=%0b", calc_error, exp_err);
        end
        check32("R5 addend after update", addend, exp_now);
        @(negedge clk);
        checks++;
        if (calc_error !== 1'b0) begin
            fails++;
            $display("FAIL R7 error pulse longer than one cycle actual=1 expected=0");
        end
        exp_old = exp_now;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check32("R1 reset addend", addend, INIT_ADD);
        check32("R1 reset local_time", local_time, 32'd0);
        check32("R1 reset busy", {31'd0, busy}, 32'd0);
        check32("R1 reset calc_error", {31'd0, calc_error}, 32'd0);
        rst_n = 1'b1;
        repeat (120) @(negedge clk);
        // R3 first Sync only stores
        do_sync(32'd1000, 32'd100, 32'd5000);
        // R5 equal rates: addend unchanged
        do_sync(32'd1001000, 32'd100, 32'd1005000);
        // R5 local slower: addend grows
        do_sync(32'd2001000, 32'd100, 32'd2004000);
        // R5 local faster: addend shrinks
        do_sync(32'd3001000, 32'd100, 32'd3005500);
        // R7 zero local interval
        do_sync(32'd4001000, 32'd100, 32'd3005500);
        // R10 previous pair stored despite the error
        do_sync(32'd5001000, 32'd100, 32'd4005300);
        // R8 negative scale
        do_sync(32'd5001100, 32'd100, 32'd5005300);
        // R8 quotient wider than 32 bits
        do_sync(32'd1078742924, 32'd100, 32'd5005301);
        // R4 wrap-around of send time plus delay
        do_sync(32'hFFFF_FF00, 32'd300, 32'd6005301);
        do_sync(32'd999_500, 32'd300, 32'd7005000);
        // R4 changed path delay shifts master time
        do_sync(32'd1999_000, 32'd900, 32'd8005000);
        // R9 strobe while busy ignored
        do_sync(32'd3000_000, 32'd900, 32'd9004000);
        do_sync(32'd4000_000, 32'd900, 32'd10004000);
        @(negedge clk);
        @(negedge clk);
        sync_tx_time = 32'd123; sync_path_delay = 32'd7; sync_rx_time = 32'd99;
        // the previous do_sync already returned with busy low: start a computation, then strobe while busy
        do_sync(32'd5000_000, 32'd900, 32'd11003000);
        exp_old = exp_now;
        m_have = m_have;
        begin
            logic [31:0] keep_mct, keep_rx;
            keep_mct = m_prev_mct;
            keep_rx  = m_prev_rx;
            // launch one real computation and inject a strobe mid-way
            fork
                do_sync(32'd6000_000, 32'd900, 32'd12002500);
                begin
                    repeat (10) @(negedge clk);
                    sync_tx_time = 32'd77; sync_path_delay = 32'd1; sync_rx_time = 32'd5;
                    sync_valid = 1'b1;
                    @(negedge clk);
                    sync_valid = 1'b0;
                end
            join
            if (keep_mct == 32'd0 && keep_rx == 32'd0) $display("note: no stored pair");
        end
        // R9 the ignored strobe must not have become the previous pair
        do_sync(32'd7000_000, 32'd900, 32'd13002000);
        repeat (200) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d cycles expected=under 150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule